// File: doc/BRIEF.md
# Prescaled Delay Timer with Vectored Interrupt

This block is one timer channel paired with its interrupt request path. A bus-clock write port sets a reload count, a mode that picks a prescale divisor (or stops the channel), enable and mask bits for the interrupt, and an 8-bit vector base register. The counter itself runs on a separate timer clock. That clock is first divided by the selected prescaler, and the divided ticks then decrement an 8-bit counter. When the counter expires it reloads from the reload register, so the channel repeats at a fixed period of prescale × reload timer-clock cycles.

Each expiry crosses into the bus clock domain as one event. The event sets a pending bit, and that bit drives an active-low request pin while the mask allows it. The acknowledge works as a valid/ready transfer. The channel offers its vector (valid) for as long as the request is active. The vector is taken in the bus cycle where the acknowledge strobe (ready) is high. The vector stays stable until it is taken, so the acknowledging side applies back-pressure simply by holding the strobe low. Taking the vector clears the pending bit. If the software end-of-interrupt option is set, taking the vector also marks the channel in service until software clears that state.

Top module: `tmr_vec_timer`

## Requirements
- R1: After an active-low reset, `irq_n` is high, `vec_vld` is low and the channel is stopped. While the mode is 0, no request appears, even with enable and mask set.
- R2: Mode (select 1, bits 2:0) values 1 to 7 choose timer-clock prescalers of 4, 10, 16, 50, 64, 100 and 200. Mode 0 stops counting. With the counter started from the reload value, successive expiries are prescale × reload timer-clock cycles apart, and a reload value of 0 counts as 256.
- R3: On every expiry the counter reloads from the reload register, so requests repeat with the same period. A reload write (select 0) while the timer runs changes only the period that starts at the next expiry.
- R4: A reload write while the mode is 0 also loads the counter directly. A timer restarted after that write expires first after prescale × new reload cycles.
- R5: Enable is bit 5 of select 2. An expiry sets the pending bit only while enable is 1, and clearing enable clears the pending bit.
- R6: Mask is bit 5 of select 3. A pending bit with mask 0 keeps `irq_n` high but stays stored, so setting mask later drives `irq_n` low at once.
- R7: The vector is {base bits 7:4, channel number 13}. The base is written to bits 7:4 of select 4, so base 0x40 gives 0x4D. `vec_vld` is high exactly while the request is active.
- R8: A cycle with `vec_vld` and `iack` both high clears the pending bit, and `irq_n` is high in the following cycle. An expiry that arrives in that same cycle keeps the pending bit set.
- R9: With the software end-of-interrupt bit (bit 3 of select 4) set, taking the vector sets an in-service state that holds `irq_n` high. Writing select 5 with bit 5 at 0 clears that state, and then a pending request drives `irq_n` low. With the bit clear, no in-service state is kept.
- R10: Each expiry sets the pending bit exactly once after it crosses into the bus domain. No expiry is lost and none is duplicated.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low asynchronous reset, both domains |
| tclk | input | 1 | Timer clock that drives the prescaler |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 3 | Register select (0 reload, 1 mode, 2 enable, 3 mask, 4 vector, 5 in-service) |
| wr_data | input | 8 | Register write data |
| iack | input | 1 | Acknowledge strobe (ready for the vector) |
| irq_n | output | 1 | Active-low interrupt request, idles high |
| vec_vld | output | 1 | Vector offered |
| vec | output | 8 | Interrupt vector |

## Verification
The main function is run through a vector table that covers every prescaler mode with a range of reload values, including 0 (meaning 256) and a long 64 × 192 period. This separates a wrong divisor from a wrong reload handling or an off-by-one in either counter. Expiry spacing is measured both from the start and across repeats, which shows whether the reload happens on every expiry. Directed patterns then set and clear enable and mask around live and stopped timers, rewrite the reload both while running and while stopped, use the software end-of-interrupt mode, and acknowledge a fast timer on every request. Together these show whether events are stored, gated, lost or duplicated.

// File: rtl/tmr_pkg.sv
`timescale 1ns/1ps
package tmr_pkg;
  localparam int BUS_W   = 8;
  localparam int MODE_W  = 3;
  localparam int SEL_W   = 3;
  localparam int PRE_W   = 8;
  localparam int CHAN_W  = 4;
  localparam int BASE_W  = BUS_W - CHAN_W;
  localparam int IRQ_BIT = 5;
  localparam int SEI_BIT = 3;

  typedef enum logic [SEL_W-1:0] {
    SEL_RELOAD = 3'd0,
    SEL_MODE   = 3'd1,
    SEL_ENABLE = 3'd2,
    SEL_MASK   = 3'd3,
    SEL_VBASE  = 3'd4,
    SEL_INSERV = 3'd5
  } reg_sel_e;

  function automatic logic [PRE_W-1:0] divisor_of(input logic [MODE_W-1:0] m);
    case (m)
      3'd1:    return PRE_W'(4);
      3'd2:    return PRE_W'(10);
      3'd3:    return PRE_W'(16);
      3'd4:    return PRE_W'(50);
      3'd5:    return PRE_W'(64);
      3'd6:    return PRE_W'(100);
      3'd7:    return PRE_W'(200);
      default: return PRE_W'(1);
    endcase
  endfunction
endpackage

// File: rtl/tmr_sync.sv
`timescale 1ns/1ps
module tmr_sync #(
  parameter int W      = 1,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stg [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < STAGES; i++) stg[i] <= '0;
    end else begin
      stg[0] <= d;
      for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/tmr_regs.sv
`timescale 1ns/1ps
module tmr_regs
  import tmr_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [SEL_W-1:0]  wr_sel,
  input  logic [BUS_W-1:0]  wr_data,
  output logic [BUS_W-1:0]  reload_q,
  output logic [MODE_W-1:0] mode_q,
  output logic              en_q,
  output logic              mask_q,
  output logic [BASE_W-1:0] vbase_q,
  output logic              sei_q,
  output logic              ld_tog_q,
  output logic              isr_clr
);
  logic stopped;
  assign stopped = (mode_q == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      reload_q <= '0;
      mode_q   <= '0;
      en_q     <= 1'b0;
      mask_q   <= 1'b0;
      vbase_q  <= '0;
      sei_q    <= 1'b0;
      ld_tog_q <= 1'b0;
    end else if (wr_en) begin
      case (wr_sel)
        SEL_RELOAD: begin
          reload_q <= wr_data;
          if (stopped) ld_tog_q <= ~ld_tog_q;
        end
        SEL_MODE:   mode_q <= wr_data[MODE_W-1:0];
        SEL_ENABLE: en_q   <= wr_data[IRQ_BIT];
        SEL_MASK:   mask_q <= wr_data[IRQ_BIT];
        SEL_VBASE: begin
          vbase_q <= wr_data[BUS_W-1:CHAN_W];
          sei_q   <= wr_data[SEI_BIT];
        end
        default: ;
      endcase
    end
  end

  assign isr_clr = wr_en && (wr_sel == SEL_INSERV) && !wr_data[IRQ_BIT];
endmodule

// File: rtl/tmr_core.sv
`timescale 1ns/1ps
module tmr_core
  import tmr_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              tclk,
  input  logic              rst_n,
  input  logic [BUS_W-1:0]  reload_a,
  input  logic [MODE_W-1:0] mode_a,
  input  logic              ld_tog_a,
  output logic              exp_tog_q
);
  logic [BUS_W-1:0]  reload_s;
  logic [MODE_W-1:0] mode_s;
  logic              ld_s, ld_prev, ld_pulse;
  logic [PRE_W-1:0]  pre_q, div;
  logic [BUS_W-1:0]  cnt_q;
  logic              running, tick;

  tmr_sync #(.W(BUS_W), .STAGES(SYNC_STAGES)) u_sync_reload (
    .clk(tclk), .rst_n(rst_n), .d(reload_a), .q(reload_s));
  tmr_sync #(.W(MODE_W), .STAGES(SYNC_STAGES)) u_sync_mode (
    .clk(tclk), .rst_n(rst_n), .d(mode_a), .q(mode_s));
  tmr_sync #(.W(1), .STAGES(SYNC_STAGES)) u_sync_ld (
    .clk(tclk), .rst_n(rst_n), .d(ld_tog_a), .q(ld_s));

  assign ld_pulse = ld_s ^ ld_prev;
  assign running  = (mode_s != '0);
  assign div      = divisor_of(mode_s);
  assign tick     = running && (pre_q >= div - PRE_W'(1));

  always_ff @(posedge tclk or negedge rst_n) begin
    if (!rst_n) begin
      ld_prev   <= 1'b0;
      pre_q     <= '0;
      cnt_q     <= '0;
      exp_tog_q <= 1'b0;
    end else begin
      ld_prev <= ld_s;
      if (!running || tick) pre_q <= '0;
      else                  pre_q <= pre_q + PRE_W'(1);
      if (ld_pulse && !running) begin
        cnt_q <= reload_s;
      end else if (tick) begin
        if (cnt_q == BUS_W'(1)) begin
          cnt_q     <= reload_s;
          exp_tog_q <= ~exp_tog_q;
        end else begin
          cnt_q <= cnt_q - BUS_W'(1);
        end
      end
    end
  end

  assert_cnt_moves_R3: assert property (@(posedge tclk) disable iff (!rst_n)
    (cnt_q != $past(cnt_q)) |-> $past(tick || ld_pulse));
  assert_stopped_quiet_R2: assert property (@(posedge tclk) disable iff (!rst_n)
    !running |=> $stable(exp_tog_q));
endmodule

// File: rtl/tmr_evsync.sv
`timescale 1ns/1ps
module tmr_evsync #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tog_a,
  output logic pulse_o
);
  logic tog_s, tog_prev;

  tmr_sync #(.W(1), .STAGES(SYNC_STAGES)) u_sync_tog (
    .clk(clk), .rst_n(rst_n), .d(tog_a), .q(tog_s));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) tog_prev <= 1'b0;
    else        tog_prev <= tog_s;
  end

  assign pulse_o = tog_s ^ tog_prev;

  assert_single_event_R10: assert property (@(posedge clk) disable iff (!rst_n)
    pulse_o |=> !pulse_o);
endmodule

// File: rtl/tmr_irq.sv
`timescale 1ns/1ps
module tmr_irq
  import tmr_pkg::*;
#(
  parameter int CHAN_ID = 13
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ev_i,
  input  logic              en_i,
  input  logic              mask_i,
  input  logic              sei_i,
  input  logic              isr_clr_i,
  input  logic              iack_i,
  input  logic [BASE_W-1:0] vbase_i,
  output logic              irq_n_o,
  output logic              vec_vld_o,
  output logic [BUS_W-1:0]  vec_o
);
  logic pend_q, isr_q, req, take;

  assign req       = pend_q && mask_i && !isr_q;
  assign take      = req && iack_i;
  assign irq_n_o   = !req;
  assign vec_vld_o = req;
  assign vec_o     = {vbase_i, CHAN_W'(CHAN_ID)};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= 1'b0;
      isr_q  <= 1'b0;
    end else begin
      if (!en_i)     pend_q <= 1'b0;
      else if (ev_i) pend_q <= 1'b1;
      else if (take) pend_q <= 1'b0;
      if (take && sei_i) isr_q <= 1'b1;
      else if (isr_clr_i) isr_q <= 1'b0;
    end
  end

  assert_pend_drop_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !en_i |=> !pend_q);
  assert_ack_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (take && !ev_i) |=> !pend_q);
  assert_inservice_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (take && sei_i) |=> (isr_q && irq_n_o));
endmodule

// File: rtl/tmr_vec_timer.sv
`timescale 1ns/1ps
module tmr_vec_timer
  import tmr_pkg::*;
#(
  parameter int CHAN_ID     = 13,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tclk,
  input  logic             wr_en,
  input  logic [SEL_W-1:0] wr_sel,
  input  logic [BUS_W-1:0] wr_data,
  input  logic             iack,
  output logic             irq_n,
  output logic             vec_vld,
  output logic [BUS_W-1:0] vec
);
  logic [BUS_W-1:0]  reload_q;
  logic [MODE_W-1:0] mode_q;
  logic              en_q, mask_q, sei_q, ld_tog_q, isr_clr;
  logic [BASE_W-1:0] vbase_q;
  logic              exp_tog, ev_pulse;

  tmr_regs u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .reload_q(reload_q), .mode_q(mode_q), .en_q(en_q), .mask_q(mask_q),
    .vbase_q(vbase_q), .sei_q(sei_q), .ld_tog_q(ld_tog_q), .isr_clr(isr_clr));

  tmr_core #(.SYNC_STAGES(SYNC_STAGES)) u_core (
    .tclk(tclk), .rst_n(rst_n), .reload_a(reload_q), .mode_a(mode_q),
    .ld_tog_a(ld_tog_q), .exp_tog_q(exp_tog));

  tmr_evsync #(.SYNC_STAGES(SYNC_STAGES)) u_evsync (
    .clk(clk), .rst_n(rst_n), .tog_a(exp_tog), .pulse_o(ev_pulse));

  tmr_irq #(.CHAN_ID(CHAN_ID)) u_irq (
    .clk(clk), .rst_n(rst_n), .ev_i(ev_pulse), .en_i(en_q), .mask_i(mask_q),
    .sei_i(sei_q), .isr_clr_i(isr_clr), .iack_i(iack), .vbase_i(vbase_q),
    .irq_n_o(irq_n), .vec_vld_o(vec_vld), .vec_o(vec));

  assert_idle_high_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !en_q |=> irq_n);
endmodule

// File: tb/tmr_vec_timer_tb.sv
`timescale 1ns/1ps
module tmr_vec_timer_tb;
  logic       clk = 1'b0, tclk = 1'b0, rst_n = 1'b0;
  logic       wr_en = 1'b0, iack = 1'b0;
  logic [2:0] wr_sel = '0;
  logic [7:0] wr_data = '0;
  logic       irq_n, vec_vld;
  logic [7:0] vec;
  int  checks = 0, fails = 0;
  bit  finished = 1'b0;

  localparam int TCK_NS = 6;
  localparam int TOL_NS = 8;
  // mode, reload, expected timer-clock cycles per period (prescale x reload)
  localparam int unsigned TAB [9][3] = '{
    '{1, 3, 12}, '{2, 5, 50}, '{3, 2, 32}, '{4, 1, 50}, '{5, 3, 192},
    '{6, 2, 200}, '{7, 1, 200}, '{1, 0, 1024}, '{5, 192, 12288}};

  always #2 clk = ~clk;
  always #3 tclk = ~tclk;

  tmr_vec_timer u_dut (
    .clk(clk), .rst_n(rst_n), .tclk(tclk), .wr_en(wr_en), .wr_sel(wr_sel),
    .wr_data(wr_data), .iack(iack), .irq_n(irq_n), .vec_vld(vec_vld), .vec(vec));

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] s, input logic [7:0] d);
    @(negedge clk); wr_en = 1'b1; wr_sel = s; wr_data = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic wait_irq(input int max_cyc, output bit seen, output longint t);
    seen = 1'b0; t = 0;
    for (int i = 0; i < max_cyc; i++) begin
      @(negedge clk);
      if (!irq_n) begin seen = 1'b1; t = $time; break; end
    end
  endtask

  task automatic take_ack(input logic [7:0] exp_vec);
    iack = 1'b1;
    check(vec_vld === 1'b1, "R7", longint'(vec_vld), 1);
    check(vec === exp_vec, "R7", longint'(vec), longint'(exp_vec));
    @(negedge clk); iack = 1'b0;
    check(irq_n === 1'b1, "R8", longint'(irq_n), 1);
  endtask

  task automatic stay_high(input int cyc, input string req);
    bit low = 1'b0;
    for (int i = 0; i < cyc; i++) begin @(negedge clk); if (!irq_n) low = 1'b1; end
    check(!low, req, longint'(low), 0);
  endtask

  task automatic quiesce();
    wr(3'd1, 8'h00);
    repeat (20) @(negedge clk);
    wr(3'd2, 8'h00);
    wr(3'd2, 8'h20);
  endtask

  initial begin
    #700000;
    if (!finished) begin
      checks++; fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    bit seen;
    longint t0, t1, t2, d, e;
    int n;
    repeat (5) @(negedge clk);
    check(irq_n === 1'b1, "R1", longint'(irq_n), 1);
    check(vec_vld === 1'b0, "R1", longint'(vec_vld), 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    wr(3'd4, 8'h40); wr(3'd2, 8'h20); wr(3'd3, 8'h20); wr(3'd0, 8'd5);
    stay_high(500, "R1");

    // table: every mode, several reload values (R2 first period, R3 repeat)
    for (int k = 0; k < 9; k++) begin
      quiesce();
      wr(3'd0, 8'(TAB[k][1]));
      wr(3'd1, 8'(TAB[k][0]));
      e = longint'(TAB[k][2]) * TCK_NS;
      wait_irq(int'(e / 4) + 80, seen, t0);
      check(seen, "R2", longint'(seen), 1);
      take_ack(8'h4D);
      wait_irq(int'(e / 4) + 20, seen, t1);
      take_ack(8'h4D);
      wait_irq(int'(e / 4) + 20, seen, t2);
      take_ack(8'h4D);
      d = t1 - t0 - e; if (d < 0) d = -d;
      check(d <= TOL_NS, "R2", t1 - t0, e);
      d = t2 - t1 - e; if (d < 0) d = -d;
      check(d <= TOL_NS, "R3", t2 - t1, e);
    end

    // R5: expiries ignored with enable clear, nothing stored
    quiesce();
    wr(3'd2, 8'h00); wr(3'd0, 8'd2); wr(3'd1, 8'd1);
    stay_high(100, "R5");
    wr(3'd1, 8'h00);
    repeat (20) @(negedge clk);
    wr(3'd2, 8'h20);
    stay_high(10, "R5");

    // R6: masked request is stored, then appears when mask set
    wr(3'd3, 8'h00); wr(3'd0, 8'd2); wr(3'd1, 8'd1);
    stay_high(40, "R6");
    wr(3'd1, 8'h00);
    repeat (20) @(negedge clk);
    wr(3'd3, 8'h20);
    check(irq_n === 1'b0, "R6", longint'(irq_n), 0);
    take_ack(8'h4D);

    // R9: software end-of-interrupt, base 0xA0 -> vector 0xAD
    quiesce();
    wr(3'd4, 8'hA8); wr(3'd0, 8'd2); wr(3'd1, 8'd1);
    wait_irq(60, seen, t0);
    check(seen, "R9", longint'(seen), 1);
    take_ack(8'hAD);
    stay_high(40, "R9");
    wr(3'd5, 8'h00);
    check(irq_n === 1'b0, "R9", longint'(irq_n), 0);
    take_ack(8'hAD);
    quiesce();
    wr(3'd5, 8'h00);
    wr(3'd4, 8'h40);
    stay_high(10, "R9");

    // R4: stopped write loads the counter directly
    wr(3'd0, 8'd200); wr(3'd1, 8'd1);
    repeat (100) @(negedge clk);
    wr(3'd1, 8'h00);
    wr(3'd0, 8'd2);
    wr(3'd1, 8'd1);
    n = 0; seen = 1'b0;
    for (int i = 0; i < 60; i++) begin
      @(negedge clk);
      if (!irq_n) begin seen = 1'b1; n = i + 1; break; end
    end
    check(seen && n >= 11 && n <= 30, "R4", longint'(n), 12);
    take_ack(8'h4D);

    // R3: running write affects only the next reload (12 -> 24 tclk)
    quiesce();
    wr(3'd0, 8'd3); wr(3'd1, 8'd1);
    wait_irq(80, seen, t0);
    take_ack(8'h4D);
    wr(3'd0, 8'd6);
    wait_irq(60, seen, t1);
    take_ack(8'h4D);
    wait_irq(80, seen, t2);
    take_ack(8'h4D);
    d = t1 - t0 - 12 * TCK_NS; if (d < 0) d = -d;
    check(d <= TOL_NS, "R3", t1 - t0, 12 * TCK_NS);
    d = t2 - t1 - 24 * TCK_NS; if (d < 0) d = -d;
    check(d <= TOL_NS, "R3", t2 - t1, 24 * TCK_NS);

    // R10: fast timer (24 ns period), every event acknowledged once
    quiesce();
    wr(3'd0, 8'd1); wr(3'd1, 8'd1);
    wait_irq(60, seen, t0);
    take_ack(8'h4D);
    n = 0;
    for (int i = 0; i < 600; i++) begin
      @(negedge clk);
      if (!irq_n) begin n++; iack = 1'b1; @(negedge clk); iack = 1'b0; i++; end
    end
    check(n >= 98 && n <= 102, "R10", longint'(n), 100);
    wr(3'd1, 8'h00);

    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule